// File: doc/BRIEF.md
# Banked Scratchpad Memory with Collision Stall

This block is a local data memory built from eight single-port banks. Four requesters share it: a store port, two load ports and a DMA port that can either read or write. Each requester presents one word address per cycle. The low address bits pick the bank, so requesters that target different banks are all served in the same cycle. Consecutive 256-bit words fall in consecutive banks.

When several requests land on one bank in the same cycle, a fixed priority picks the winner: the store port first, then load port 0, then load port 1, then the DMA port. Each losing request is copied into a one-entry holding register for its port. That port's stall output stays high until the held request has been served, so nothing is dropped. Read data comes back on the requesting port a fixed number of cycles after the request is accepted.

Every stored word carries an even-parity bit. A read whose data and parity disagree sets a sticky error flag. A clear pulse resets the flag. The store port can write a deliberately wrong parity bit so that the check path can be exercised.

Top module: `spm_banked`

## Requirements
- R1: An address selects bank addr[2:0] and row addr[9:3]. There are 8 banks of 128 words of 256 bits (32 KB). A read returns the last data written to that address by either write port.
- R2: Requests that all target different banks in one cycle are all accepted in that cycle, and no port stalls the next cycle.
- R3: A read accepted at the end of cycle c raises its port's rvalid for exactly one cycle, in cycle c+5, with the read data.
- R4: When several requests meet on one bank, the winner is the first of: store, load 0, load 1, DMA.
- R5: A port that loses arbitration in cycle c has its stall output high from cycle c+1. The stall stays high until the cycle after its held request is served. Requests presented on a stalled port are ignored.
- R6: A held request is served in the first cycle its bank is free of higher-priority requests. Its effect is the same as if it had been accepted when presented: read data for the held address, or the write performed. No request is dropped.
- R7: The store port never stalls.
- R8: Each stored word keeps a parity bit equal to the XOR of its data bits. A store with st_perr_inj_i=1 stores the inverted bit. A read of a word whose data and parity disagree sets perr_o from the cycle after its rvalid cycle. Reads of good words leave perr_o low.
- R9: perr_o stays high until a cycle with perr_clr_i=1, and reads 0 from the next cycle. If a new error and the clear fall in the same cycle, the flag stays set.
- R10: The DMA port writes when dma_we_i=1, storing correct parity and producing no rvalid. It reads when dma_we_i=0, with the same latency as the load ports.
- R11: During and right after reset, all stall outputs, all rvalid outputs and perr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_req_i | input | 1 | Store request |
| st_addr_i | input | 10 | Store word address |
| st_wdata_i | input | 256 | Store data |
| st_perr_inj_i | input | 1 | Store writes inverted parity |
| st_stall_o | output | 1 | Store port busy |
| ld_req_i | input | 2 | Load requests, one per load port |
| ld_addr_i | input | 2x10 | Load word addresses |
| ld_stall_o | output | 2 | Load port busy with a held request |
| ld_rvalid_o | output | 2 | Load data valid |
| ld_rdata_o | output | 2x256 | Load data |
| dma_req_i | input | 1 | DMA request |
| dma_we_i | input | 1 | DMA write (1) or read (0) |
| dma_addr_i | input | 10 | DMA word address |
| dma_wdata_i | input | 256 | DMA write data |
| dma_stall_o | output | 1 | DMA port busy with a held request |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 256 | DMA read data |
| perr_o | output | 1 | Sticky parity error flag |
| perr_clr_i | input | 1 | Clears the parity error flag |

## Verification
The properties assume that reset is applied before the first request and that request and write-enable inputs never carry unknown values. They do not assume that requesters back off while stalled, because a held request masks its port's input. The stimulus deliberately presents one request on a stalled port to show that it is ignored; otherwise it waits for stall to drop. Loads only target addresses written earlier, so the parity flag can only come from the injected faults.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int NPORT = 4;
    localparam int NRD   = 3;
    localparam int P_ST  = 0;
    localparam int P_LD0 = 1;
    localparam int P_LD1 = 2;
    localparam int P_DMA = 3;
endpackage

// File: rtl/spm_arb.sv
module spm_arb #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] want_i,
    output logic [N-1:0] gnt_o
);
    // lowest index has the highest priority
    always_comb begin
        gnt_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
            end
        end
    end

    a_r4_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    a_r4_grant_is_wanted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o & ~want_i) == '0);
    a_r4_top_priority_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want_i[0] |-> gnt_o[0]);
    a_r4_no_idle_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|want_i) |-> (|gnt_o));
endmodule

// File: rtl/spm_bank.sv
module spm_bank #(
    parameter  int DATA_W = 256,
    parameter  int DEPTH  = 128,
    localparam int ROW_W  = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              en_i,
    input  logic              we_i,
    input  logic              inj_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              perr_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  par_q;

    always_ff @(posedge clk_i) begin
        if (en_i && we_i) begin
            mem_q[row_i] <= wdata_i;
            par_q[row_i] <= (^wdata_i) ^ inj_i;
        end
    end

    assign rdata_o = mem_q[row_i];
    assign perr_o  = en_i & ~we_i & ((^mem_q[row_i]) ^ par_q[row_i]);
endmodule

// File: rtl/spm_rdpipe.sv
module spm_rdpipe #(
    parameter int DATA_W = 256,
    parameter int LAT    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_v_i,
    input  logic              in_err_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_v_o,
    output logic              out_err_o,
    output logic [DATA_W-1:0] out_data_o
);
    typedef struct packed {
        logic              v;
        logic              err;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t [LAT-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0].v    = in_v_i;
        pipe_d[0].err  = in_err_i;
        pipe_d[0].data = in_data_i;
        for (int k = 1; k < LAT; k++) pipe_d[k] = pipe_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign out_v_o    = pipe_q[LAT-1].v;
    assign out_err_o  = pipe_q[LAT-1].err;
    assign out_data_o = pipe_q[LAT-1].data;

    // checker: reads in flight never exceed the pipeline depth
    logic [7:0] inflight_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) inflight_q <= '0;
        else         inflight_q <= inflight_q + 8'(in_v_i) - 8'(out_v_o);
    end
    a_r3_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inflight_q <= 8'(LAT));
endmodule

// File: rtl/spm_banked.sv
module spm_banked
    import spm_pkg::*;
#(
    parameter  int DATA_W = 256,
    parameter  int BANKS  = 8,
    parameter  int DEPTH  = 128,
    parameter  int RD_LAT = 5,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int ADDR_W = BANK_W + ROW_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   st_req_i,
    input  logic [ADDR_W-1:0]      st_addr_i,
    input  logic [DATA_W-1:0]      st_wdata_i,
    input  logic                   st_perr_inj_i,
    output logic                   st_stall_o,
    input  logic [1:0]             ld_req_i,
    input  logic [1:0][ADDR_W-1:0] ld_addr_i,
    output logic [1:0]             ld_stall_o,
    output logic [1:0]             ld_rvalid_o,
    output logic [1:0][DATA_W-1:0] ld_rdata_o,
    input  logic                   dma_req_i,
    input  logic                   dma_we_i,
    input  logic [ADDR_W-1:0]      dma_addr_i,
    input  logic [DATA_W-1:0]      dma_wdata_i,
    output logic                   dma_stall_o,
    output logic                   dma_rvalid_o,
    output logic [DATA_W-1:0]      dma_rdata_o,
    output logic                   perr_o,
    input  logic                   perr_clr_i
);
    typedef struct packed {
        logic              v;
        logic              we;
        logic              inj;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        req_t [NPORT-1:0] hold;
        logic             perr;
    } state_t;

    state_t st_d, st_q;
    req_t [NPORT-1:0] in_req, eff;
    logic [BANKS-1:0][NPORT-1:0] want, gnt;
    logic [NPORT-1:0] win, stall_w;
    req_t [BANKS-1:0] bank_req;
    logic [DATA_W-1:0] bank_rdata [BANKS];
    logic [BANKS-1:0]  bank_perr;
    logic [NRD-1:0]    rd_v, rd_err, rv, re;
    logic [DATA_W-1:0] rd_data [NRD];
    logic [DATA_W-1:0] rv_data [NRD];

    // requests as presented at the ports
    always_comb begin
        in_req = '0;
        in_req[P_ST]  = '{v: st_req_i, we: 1'b1, inj: st_perr_inj_i,
                          addr: st_addr_i, wdata: st_wdata_i};
        in_req[P_LD0] = '{v: ld_req_i[0], we: 1'b0, inj: 1'b0,
                          addr: ld_addr_i[0], wdata: '0};
        in_req[P_LD1] = '{v: ld_req_i[1], we: 1'b0, inj: 1'b0,
                          addr: ld_addr_i[1], wdata: '0};
        in_req[P_DMA] = '{v: dma_req_i, we: dma_we_i, inj: 1'b0,
                          addr: dma_addr_i, wdata: dma_wdata_i};
    end

    // a held request replaces whatever the port presents
    always_comb begin
        for (int p = 0; p < NPORT; p++)
            eff[p] = st_q.hold[p].v ? st_q.hold[p] : in_req[p];
        for (int b = 0; b < BANKS; b++)
            for (int p = 0; p < NPORT; p++)
                want[b][p] = eff[p].v && (eff[p].addr[BANK_W-1:0] == BANK_W'(b));
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spm_arb #(.N(NPORT)) u_arb (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .want_i (want[b]),
            .gnt_o  (gnt[b])
        );

        always_comb begin
            bank_req[b] = '0;
            for (int p = 0; p < NPORT; p++)
                if (gnt[b][p]) bank_req[b] = eff[p];
        end

        spm_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk_i   (clk_i),
            .en_i    (bank_req[b].v),
            .we_i    (bank_req[b].we),
            .inj_i   (bank_req[b].inj),
            .row_i   (bank_req[b].addr[ADDR_W-1:BANK_W]),
            .wdata_i (bank_req[b].wdata),
            .rdata_o (bank_rdata[b]),
            .perr_o  (bank_perr[b])
        );
    end

    always_comb begin
        win = '0;
        for (int b = 0; b < BANKS; b++) win = win | gnt[b];
        for (int r = 0; r < NRD; r++) begin
            rd_v[r]    = eff[r+1].v & win[r+1] & ~eff[r+1].we;
            rd_data[r] = bank_rdata[eff[r+1].addr[BANK_W-1:0]];
            rd_err[r]  = bank_perr[eff[r+1].addr[BANK_W-1:0]];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        spm_rdpipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_pipe (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .in_v_i     (rd_v[r]),
            .in_err_i   (rd_err[r]),
            .in_data_i  (rd_data[r]),
            .out_v_o    (rv[r]),
            .out_err_o  (re[r]),
            .out_data_o (rv_data[r])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPORT; p++) begin
            if (st_q.hold[p].v) begin
                if (win[p]) st_d.hold[p].v = 1'b0;
            end else if (in_req[p].v && !win[p]) begin
                st_d.hold[p] = in_req[p];
            end
        end
        st_d.perr = (st_q.perr & ~perr_clr_i) | (|(rv & re));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) stall_w[p] = st_q.hold[p].v;
    end

    assign st_stall_o     = stall_w[P_ST];
    assign ld_stall_o     = {stall_w[P_LD1], stall_w[P_LD0]};
    assign dma_stall_o    = stall_w[P_DMA];
    assign ld_rvalid_o    = rv[1:0];
    assign ld_rdata_o[0]  = rv_data[0];
    assign ld_rdata_o[1]  = rv_data[1];
    assign dma_rvalid_o   = rv[2];
    assign dma_rdata_o    = rv_data[2];
    assign perr_o         = st_q.perr;

    a_r7_store_never_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_stall_o);
    a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (perr_o && !perr_clr_i) |=> perr_o);

    for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
        a_r6_loser_buffered: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stall_w[p] && in_req[p].v && !win[p]) |=> stall_w[p]);
        a_r5_release_after_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stall_w[p] && win[p]) |=> !stall_w[p]);
        a_r5_stall_until_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stall_w[p] && !win[p]) |=> stall_w[p]);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
        a_r2_sole_request_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($countones(want[b]) == 1) |-> ((win & want[b]) == want[b]));
    end
endmodule

// File: tb/spm_banked_bench.sv
module spm_banked_bench;
    localparam int DW  = 256;
    localparam int AW  = 10;
    localparam int LAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                st_req = 0, st_inj = 0, st_stall;
    logic [AW-1:0]       st_addr = '0;
    logic [DW-1:0]       st_wdata = '0;
    logic [1:0]          ld_req = '0, ld_stall, ld_rvalid;
    logic [1:0][AW-1:0]  ld_addr = '0;
    logic [1:0][DW-1:0]  ld_rdata;
    logic                dma_req = 0, dma_we = 0, dma_stall, dma_rvalid;
    logic [AW-1:0]       dma_addr = '0;
    logic [DW-1:0]       dma_wdata = '0, dma_rdata;
    logic                perr, perr_clr = 0;

    spm_banked u_spm_banked (
        .clk_i(clk), .rst_ni(rst_n),
        .st_req_i(st_req), .st_addr_i(st_addr), .st_wdata_i(st_wdata),
        .st_perr_inj_i(st_inj), .st_stall_o(st_stall),
        .ld_req_i(ld_req), .ld_addr_i(ld_addr), .ld_stall_o(ld_stall),
        .ld_rvalid_o(ld_rvalid), .ld_rdata_o(ld_rdata),
        .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr),
        .dma_wdata_i(dma_wdata), .dma_stall_o(dma_stall),
        .dma_rvalid_o(dma_rvalid), .dma_rdata_o(dma_rdata),
        .perr_o(perr), .perr_clr_i(perr_clr)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic [DW-1:0] d; int at; } exp_t;
    exp_t q0[$], q1[$], q2[$];
    int n_push[3] = '{0, 0, 0};
    int n_seen[3] = '{0, 0, 0};
    logic [DW-1:0] mdl [int];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a, int s);
        logic [DW-1:0] r;
        for (int i = 0; i < DW / 32; i++)
            r[i*32 +: 32] = 32'(a * 32'h0100_0193) ^ 32'(s * 32'h9E37_79B9) ^ 32'(i << 4);
        return r;
    endfunction

    task automatic pop_cmp(ref exp_t q[$], input logic [DW-1:0] act, input string tag);
        exp_t e;
        if (q.size() == 0) begin
            check(0, "R5", {tag, " unexpected rvalid"}, 1, 0);
        end else begin
            e = q.pop_front();
            check(act == e.d, "R1", {tag, " read data"}, act, e.d);
            check(cyc == e.at, "R3", {tag, " return cycle"}, DW'(cyc), DW'(e.at));
        end
    endtask

    // monitor: samples one time unit after each rising edge
    initial forever begin
        @(posedge clk); #1;
        if (rst_n) begin
            if (ld_rvalid[0]) begin n_seen[0]++; pop_cmp(q0, ld_rdata[0], "load0"); end
            if (ld_rvalid[1]) begin n_seen[1]++; pop_cmp(q1, ld_rdata[1], "load1"); end
            if (dma_rvalid)   begin n_seen[2]++; pop_cmp(q2, dma_rdata, "dma"); end
        end
    end

    // driver helpers: called right after a falling edge
    task automatic do_store(input int a, input int s, input bit inj);
        st_req = 1; st_addr = AW'(a); st_wdata = pat(a, s); st_inj = inj;
        mdl[a] = pat(a, s);
    endtask

    task automatic do_load(input int k, input int a, input int delay);
        exp_t e;
        ld_req[k] = 1; ld_addr[k] = AW'(a);
        e.d = mdl[a]; e.at = cyc + LAT + delay;
        if (k == 0) q0.push_back(e); else q1.push_back(e);
        n_push[k]++;
    endtask

    task automatic do_dma_rd(input int a, input int delay);
        exp_t e;
        dma_req = 1; dma_we = 0; dma_addr = AW'(a);
        e.d = mdl[a]; e.at = cyc + LAT + delay;
        q2.push_back(e); n_push[2]++;
    endtask

    task automatic do_dma_wr(input int a, input int s);
        dma_req = 1; dma_we = 1; dma_addr = AW'(a); dma_wdata = pat(a, s);
        mdl[a] = pat(a, s);
    endtask

    task automatic next();
        @(negedge clk);
        st_req = 0; st_inj = 0; ld_req = '0; dma_req = 0; dma_we = 0; perr_clr = 0;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) next();
    endtask

    task automatic chk_stall(input bit s0, input bit s1, input bit sd, input string rq);
        check(ld_stall[0] == s0, rq, "load0 stall", DW'(ld_stall[0]), DW'(s0));
        check(ld_stall[1] == s1, rq, "load1 stall", DW'(ld_stall[1]), DW'(s1));
        check(dma_stall == sd, rq, "dma stall", DW'(dma_stall), DW'(sd));
        check(st_stall == 0, "R7", "store stall", DW'(st_stall), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk_stall(0, 0, 0, "R11");
        check(ld_rvalid == 0 && !dma_rvalid, "R11", "rvalid in reset", DW'({ld_rvalid, dma_rvalid}), 0);
        check(perr == 0, "R11", "perr in reset", DW'(perr), 0);
        rst_n = 1;
        next();
        chk_stall(0, 0, 0, "R11");
        check(perr == 0, "R11", "perr after reset", DW'(perr), 0);

        // fill: store words 0..15, DMA writes words 16..23 (R10)
        for (int a = 0; a < 16; a++) begin do_store(a, 1, 0); next(); end
        for (int a = 16; a < 24; a++) begin
            do_dma_wr(a, 2); next();
            check(dma_stall == 0, "R10", "dma write stall", DW'(dma_stall), 0);
        end

        // R2: four requesters, four different banks
        do_store(40, 3, 0); do_load(0, 1, 0); do_load(1, 2, 0); do_dma_rd(3, 0);
        next();
        chk_stall(0, 0, 0, "R2");

        // R4/R5/R6: all four collide on bank 5
        c = cyc;
        do_store(37, 4, 0); do_load(0, 5, 1); do_load(1, 13, 2); do_dma_rd(21, 3);
        next();
        chk_stall(1, 1, 1, "R5");
        ld_req[1] = 1; ld_addr[1] = AW'(0);  // R5: ignored while stalled
        next();
        chk_stall(0, 1, 1, "R4");
        next();
        chk_stall(0, 0, 1, "R4");
        next();
        chk_stall(0, 0, 0, "R6");

        // R4: load1 beats DMA on bank 6, then load0 beats load1 on bank 7
        do_load(1, 6, 0); do_dma_rd(14, 1);
        next();
        chk_stall(0, 0, 1, "R4");
        next();
        do_load(0, 7, 0); do_load(1, 15, 1);
        next();
        chk_stall(0, 1, 0, "R4");
        next();

        // R6: store and load to the same word; load sees the new data
        do_store(9, 5, 0); do_load(0, 9, 1);
        next();
        chk_stall(1, 0, 0, "R6");
        next();

        // R6: held DMA write is not dropped
        do_store(2, 6, 0); do_dma_wr(58, 7);
        next();
        chk_stall(0, 0, 1, "R6");
        next();
        chk_stall(0, 0, 0, "R6");
        do_load(1, 58, 0);
        next();

        // R2/R3: streaming loads to distinct banks every cycle
        for (int i = 0; i < 40; i++) begin
            do_load(0, i % 16, 0);
            do_load(1, 16 + ((i + 3) % 8), 0);
            next();
            check(ld_stall == 0, "R2", "streaming stall", DW'(ld_stall), 0);
        end
        wait_to(cyc + LAT + 2);
        check(perr == 0, "R8", "no error on good reads", DW'(perr), 0);

        // R8: injected parity error
        do_store(50, 8, 1);
        next();
        c = cyc;
        do_load(0, 50, 0);
        next();
        wait_to(c + LAT);
        check(perr == 0, "R8", "flag before rvalid cycle ends", DW'(perr), 0);
        next();
        check(perr == 1, "R8", "flag after bad read", DW'(perr), 1);
        next(); next(); next();
        check(perr == 1, "R9", "flag sticky", DW'(perr), 1);
        perr_clr = 1;
        next();
        check(perr == 0, "R9", "flag cleared", DW'(perr), 0);

        // R9: set wins over clear in the same cycle
        c = cyc;
        do_dma_rd(50, 0);
        next();
        wait_to(c + LAT);
        perr_clr = 1;
        next();
        check(perr == 1, "R9", "set beats clear", DW'(perr), 1);
        perr_clr = 1;
        next();
        check(perr == 0, "R9", "second clear", DW'(perr), 0);

        // R10/R8: DMA overwrite stores good parity
        do_dma_wr(50, 9);
        next();
        c = cyc;
        do_dma_rd(50, 0);
        next();
        wait_to(c + LAT + 2);
        check(perr == 0, "R10", "dma write parity good", DW'(perr), 0);

        wait_to(cyc + LAT + 4);
        for (int k = 0; k < 3; k++)
            check(n_seen[k] == n_push[k], "R6", "reads returned vs issued",
                  DW'(n_seen[k]), DW'(n_push[k]));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule